// File: doc/BRIEF.md
# Nested Interrupt Pending and Priority Controller

This block holds the interrupt pending and interrupt mask state for a parameterised set of channels. Each channel is requested either by a level-sensitive external line or by a latch that software sets through a small register port. Among the channels that are both requesting and unmasked, the block picks the one with the highest number. It offers that channel to the core over a take handshake.

A nesting counter tracks how deep the core is in trap handlers. Alongside the counter, the block keeps a record of the channel being served at each depth. A running handler is preempted only by a strictly higher channel. A trap-return strobe unwinds one level. Channel 0 is the software context-switch request: it is granted at once from thread mode (level 0). In trap mode it waits until every handler has returned.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the nesting level is 0, all latches and all mask bits are 0, both register reads return 0, and `take_valid` is low.
- R2: With `csr_sel`=0, a read returns the bitwise OR of the external lines and the latches. A write with `csr_sel`=0 replaces the latches with `csr_wdata` from the next cycle and leaves the external lines unaffected.
- R3: With `csr_sel`=1, the mask register is read and written. A channel whose mask bit is 0 is never offered on the take port.
- R4: When several unmasked channels request, `take_chan` reports the highest channel number among them.
- R5: When `take_valid` and `take_ready` are both high, the latch of the reported channel is cleared in the next cycle. This clear wins over a same-cycle software write. An external line keeps its channel requesting.
- R6: A completed take raises `level` by one in the next cycle. A trap return at a non-zero level lowers it by one. Level 0 is thread mode.
- R7: At a non-zero level, a request is offered only when its channel number is strictly greater than the channel taken at the current level.
- R8: A channel 0 request is offered at level 0 and is held back at any non-zero level until the level returns to 0.
- R9: At level `MAX_LVL` nothing is offered, so the level never exceeds it. A trap return at level 0 leaves the level at 0.
- R10: While `tret` is high, `take_valid` is low, so a take and a return never occur in the same cycle.
- R11: Channels at or above `NEXT` have no external line. Their read bits follow only the latches.
- R12: After a trap return, the preemption threshold is again the channel that was taken at the level returned to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 pending/assert, 1 mask |
| csr_wdata | input | NCH | Write data |
| csr_rdata | output | NCH | Read data of the selected register (combinational) |
| ext_irq | input | NEXT | External level-sensitive lines for channels 0..NEXT-1 |
| take_valid | output | 1 | A channel may be taken now |
| take_ready | input | 1 | Core accepts the offered channel |
| take_chan | output | $clog2(NCH) | Offered channel number |
| tret | input | 1 | Trap-return strobe |
| level | output | $clog2(MAX_LVL+1) | Current nesting level |

## Verification
The take port and register reads are combinational from the registered state and the current inputs. They are therefore compared in the same cycle that the stimulus is applied, one time unit after inputs change at the falling edge. Latch writes, latch clears, mask writes and level changes all pass through one register, so their effects are due at the following falling edge, where the next comparison reads them. A bench model advances its state only at the rising edge, which keeps its expectations aligned to that one-cycle delay.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int NCH = 32,
  parameter int NEXT = 24,
  parameter int MAX_LVL = 7,
  localparam int CW = $clog2(NCH),
  localparam int LW = $clog2(MAX_LVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_we,
  input  logic           csr_sel,
  input  logic [NCH-1:0] csr_wdata,
  output logic [NCH-1:0] csr_rdata,
  input  logic [NEXT-1:0] ext_irq,
  output logic           take_valid,
  input  logic           take_ready,
  output logic [CW-1:0]  take_chan,
  input  logic           tret,
  output logic [LW-1:0]  level
);

  logic [NCH-1:0] latch_q, ie_q, line, req, latch_nx;
  logic [CW-1:0]  act_q [0:MAX_LVL];
  logic [LW-1:0]  level_q;
  logic [CW-1:0]  cand;
  logic           found, take;

  always_comb begin
    line = '0;
    line[NEXT-1:0] = ext_irq;
  end

  assign req = (line | latch_q) & ie_q;

  always_comb begin
    cand = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (req[i]) begin
        cand = CW'(i);
        found = 1'b1;
      end
  end

  assign take_valid = found && !tret && (level_q != LW'(MAX_LVL)) &&
                      ((level_q == '0) || (cand > act_q[level_q]));
  assign take_chan = cand;
  assign take = take_valid && take_ready;
  assign level = level_q;
  assign csr_rdata = csr_sel ? ie_q : (line | latch_q);

  always_comb begin
    latch_nx = (csr_we && !csr_sel) ? csr_wdata : latch_q;
    if (take) latch_nx[cand] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      ie_q <= '0;
      level_q <= '0;
      for (int i = 0; i <= MAX_LVL; i++) act_q[i] <= '0;
    end else begin
      latch_q <= latch_nx;
      if (csr_we && csr_sel) ie_q <= csr_wdata;
      if (take) begin
        level_q <= level_q + 1'b1;
        act_q[level_q + 1'b1] <= cand;
      end else if (tret && level_q != '0) begin
        level_q <= level_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int NCH = 32,
  parameter int MAX_LVL = 7,
  localparam int CW = $clog2(NCH),
  localparam int LW = $clog2(MAX_LVL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           take_valid,
  input logic           take_ready,
  input logic [CW-1:0]  take_chan,
  input logic           tret,
  input logic [LW-1:0]  level,
  input logic [NCH-1:0] latch_q,
  input logic [NCH-1:0] ie_q
);

  p_take_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ready |=> level == $past(level) + 1'b1);

  p_tret_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tret && level != '0 |=> level == $past(level) - 1'b1);

  p_tret_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tret && level == '0 |=> level == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level == LW'(MAX_LVL) |-> !take_valid);

  p_tret_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tret |-> !take_valid);

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> ie_q[take_chan]);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ready |=> !latch_q[$past(take_chan)]);

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NCH(NCH), .MAX_LVL(MAX_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_ready(take_ready),
  .take_chan(take_chan), .tret(tret), .level(level),
  .latch_q(latch_q), .ie_q(ie_q)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
  localparam int NCH = 32, NEXT = 24, MAX_LVL = 7;
  localparam int CW = $clog2(NCH), LW = $clog2(MAX_LVL + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 0, csr_sel = 0, take_ready = 0, tret = 0;
  logic [NCH-1:0] csr_wdata = '0, csr_rdata;
  logic [NEXT-1:0] ext_irq = '0;
  logic take_valid;
  logic [CW-1:0] take_chan;
  logic [LW-1:0] level;

  int checks = 0, errors = 0, cyc = 0;

  logic [NCH-1:0] m_latch = '0, m_ie = '0;
  int m_lvl = 0;
  int m_act [0:MAX_LVL];

  always #2.5 clk = ~clk;

  irq_nest_ctrl #(.NCH(NCH), .NEXT(NEXT), .MAX_LVL(MAX_LVL)) i_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ext_irq(ext_irq),
    .take_valid(take_valid), .take_ready(take_ready), .take_chan(take_chan),
    .tret(tret), .level(level));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [NCH-1:0] m_lines();
    logic [NCH-1:0] l = '0;
    l[NEXT-1:0] = ext_irq;
    return l;
  endfunction

  function automatic int m_top();
    logic [NCH-1:0] r = (m_lines() | m_latch) & m_ie;
    int c = -1;
    for (int i = 0; i < NCH; i++) if (r[i]) c = i;
    return c;
  endfunction

  function automatic bit m_valid();
    int c = m_top();
    if (c < 0 || tret || m_lvl == MAX_LVL) return 0;
    return (m_lvl == 0) || (c > m_act[m_lvl]);
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // inputs already driven after a falling edge
  task automatic step(string tag);
    bit v;
    int c;
    #1;
    v = m_valid();
    c = m_top();
    chk(tag, "take_valid", take_valid, v);
    if (v) chk(tag, "take_chan", take_chan, c);
    chk(tag, "level", level, m_lvl);
    chk(tag, "rdata", csr_rdata, csr_sel ? m_ie : (m_lines() | m_latch));
    @(posedge clk);
    if (csr_we && !csr_sel) m_latch = csr_wdata;
    if (csr_we && csr_sel) m_ie = csr_wdata;
    if (v && take_ready) begin
      m_latch[c] = 1'b0;
      m_lvl++;
      m_act[m_lvl] = c;
    end else if (tret && m_lvl != 0) m_lvl--;
    @(negedge clk);
    csr_we = 0; take_ready = 0; tret = 0;
  endtask

  task automatic wr(bit sel, logic [NCH-1:0] d, string tag);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    step(tag);
  endtask

  task automatic take(string tag);
    take_ready = 1;
    step(tag);
  endtask

  task automatic ret(string tag);
    tret = 1;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i <= MAX_LVL; i++) m_act[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    csr_sel = 0; step("R1");
    csr_sel = 1; step("R1");

    // R2: read OR, write only latches
    csr_sel = 0; ext_irq = 24'h000011;
    wr(0, 32'h0000_0102, "R2");
    step("R2");
    ext_irq = '0; step("R2");

    // R11: upper channels have no line
    ext_irq = '1; csr_sel = 0; step("R11");
    wr(0, 32'h8000_0000, "R11");
    step("R11");
    ext_irq = '0; wr(0, '0, "R11");

    // R3: mask
    wr(1, 32'h0000_00F0, "R3");
    csr_sel = 1; step("R3");
    ext_irq = 24'h000003; step("R3");
    take("R3");
    ext_irq = '0;

    // R4 / R5 / R6
    wr(1, '1, "R4");
    wr(0, 32'h0040_0024, "R4");
    take("R4");          // ch22 taken, level 1
    csr_sel = 0; step("R5");
    ret("R6");
    take("R5");          // ch5
    ret("R6");

    // R5: clear beats same-cycle write
    wr(0, 32'h0000_0200, "R5");
    csr_we = 1; csr_sel = 0; csr_wdata = 32'h0000_0300; take_ready = 1; step("R5");
    csr_sel = 0; step("R5");
    ret("R5");
    wr(0, '0, "R5");

    // R7 / R12: nesting
    ext_irq = 24'h000100; take("R7");  // ch8, level1
    wr(0, 32'h0000_0010, "R7");        // ch4 lower, blocked
    step("R7");
    ext_irq = 24'h100000; take("R7");  // ch20, level2
    ext_irq = 24'h010000; step("R7");  // ch16 below 20
    ret("R12");                         // back to level1, threshold 8
    take("R12");                        // ch16 > 8
    ext_irq = '0; ret("R12"); ret("R12");
    take("R12"); ret("R12");           // ch4 latch at level 0
    wr(0, '0, "R12");

    // R8: channel 0 deferred
    ext_irq = 24'h000002; take("R8");  // ch1, level1
    ext_irq = '0;
    wr(0, 32'h1, "R8");
    step("R8");
    ret("R8");
    step("R8");
    take("R8");
    ret("R8");

    // R9: saturation and floor
    ret("R9"); ret("R9");
    for (int i = 0; i < MAX_LVL; i++) begin
      wr(0, 32'h1 << (i + 1), "R9");
      take("R9");
    end
    wr(0, 32'h8000_0000, "R9");
    take("R9");
    for (int i = 0; i < MAX_LVL; i++) ret("R9");
    wr(0, '0, "R9");

    // R10: tret blocks take
    ext_irq = 24'h000040;
    tret = 1; take_ready = 1; step("R10");
    take("R10"); ext_irq = '0; ret("R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      ext_irq = (($urandom % 4) == 0) ? NEXT'($urandom & $urandom & $urandom) : '0;
      csr_sel = $urandom % 2;
      if (($urandom % 6) == 0) begin
        csr_we = 1;
        csr_wdata = csr_sel ? (($urandom % 3 == 0) ? NCH'($urandom) : '1)
                            : NCH'($urandom & $urandom);
      end
      take_ready = $urandom % 2;
      tret = ($urandom % 4) == 0;
      step("R4");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule